// File: doc/BRIEF.md
# Exception Stack Frame Sequencer

This block performs the memory side of exception entry and exception return for a processor core. On an entry request it takes the exception vector number, the frame format to build, an optional hardware-interrupt flag with its pending priority level, and the core's current program counter, status register and the two supervisor stack pointers (interrupt stack and master stack). It forms the new status register, pushes a typed frame downward on the selected supervisor stack, and reads the handler address from the vector table. On a return request it pops the status register, the program counter and the format word, then steps the stack pointer past whatever extra words the format code implies.

All memory traffic goes through a single valid/ready port that carries either a 16-bit word or a 32-bit longword, one access at a time, big-endian. The core holds its state while `busy` is high and takes the new PC, SR and stack pointers when `done` pulses. Interrupts arriving while the master stack is active produce two frames: a format-0 frame on the master stack and a format-1 "throwaway" frame on the interrupt stack. A return that meets a format-1 frame restores its SR and starts popping again from whichever stack that SR selects.

Top module: `exc_frame_seq`

## Requirements
- R1: An entry with `hw_irq` high is accepted only when the SR mask field (bits 10:8) is strictly below `irq_level`; otherwise `done` pulses with `irq_rejected` high, no memory access is made and the `new_*` outputs equal the current inputs.
- R2: On an accepted entry the new SR is the old SR with bit 13 (supervisor) set and bit 15 (trace) cleared; for a hardware interrupt bits 10:8 are loaded with `irq_level`. The SR word stacked in the frame is the old, unmodified SR.
- R3: A frame is pushed from high to low addresses as: format word `{format[3:0], vector, 2'b00}` (16 bits), return address (32 bits), stacked SR (16 bits), so the SR sits at the final stack pointer. The stack used is the master stack when bit 12 of the new SR is set, otherwise the interrupt stack.
- R4: Formats 2 and 3 push `fault_addr` as one longword above the format word; format 4 pushes `cur_pc` first and then `fault_addr`; formats 0 and 1 push no extra words. Hardware interrupts always use format 0.
- R5: For software exceptions with vector numbers 32 to 47 the stacked return address is `cur_pc + 2`; for all other vectors it is `cur_pc`.
- R6: A hardware interrupt with vector 24 to 31 taken while old SR bit 12 is set pushes a format-0 frame on the master stack, then pushes a format-1 frame on the interrupt stack that stacks the updated SR with bit 12 still set; the final SR has bit 12 cleared and both stack pointers are updated.
- R7: After stacking, the block reads a longword at `vbr + vector*4` and returns it as `new_pc`.
- R8: With `UNALIGNED_OK` = 0, bit 0 of each stack pointer is cleared before the first push onto it.
- R9: A return reads a word SR at SP, a longword PC at SP+2 and a format word at SP+6 from the stack chosen by bit 12 of `cur_sr`; the final SP is SP+8 plus 0 for format 0, 4 for formats 2 and 3, 8 for format 4 and 52 for format 7, and `new_sr`/`new_pc` take the popped values.
- R10: A return that pops format 1 writes SP+8 back to the current stack, takes the popped SR as current SR, and restarts popping from the stack selected by bit 12 of that SR.
- R11: A return that pops a format code outside {0,1,2,3,4,7}, or an entry requesting a format outside {0,2,3,4}, pulses `done` with `fmt_err` high and leaves `new_pc`, `new_sr`, `new_isp` and `new_msp` at the values presented at the start.
- R12: Once `mem_valid` is raised it stays high with address, data, direction and size stable until `mem_ready`; `busy` is high during every access and low when `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_entry | input | 1 | Begin exception entry (sampled when idle) |
| start_return | input | 1 | Begin exception return (sampled when idle) |
| vec_num | input | VEC_W | Exception vector number |
| entry_fmt | input | 4 | Frame format for a software exception |
| hw_irq | input | 1 | Entry is a hardware interrupt |
| irq_level | input | 3 | Pending interrupt priority level |
| fault_addr | input | 32 | Address stored in format 2/3/4 frames |
| cur_pc | input | 32 | Current program counter |
| vbr | input | 32 | Vector table base |
| cur_sr | input | 16 | Current status register |
| cur_isp | input | 32 | Current interrupt stack pointer |
| cur_msp | input | 32 | Current master stack pointer |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_long | output | 1 | 1 = 32-bit access, 0 = 16-bit access |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data (word in bits 15:0) |
| mem_ready | input | 1 | Memory accepts/completes the access |
| mem_rdata | input | 32 | Read data (word in bits 15:0) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fmt_err | output | 1 | Unsupported format (valid with done) |
| irq_rejected | output | 1 | Interrupt masked (valid with done) |
| new_pc | output | 32 | Resulting program counter |
| new_sr | output | 16 | Resulting status register |
| new_isp | output | 32 | Resulting interrupt stack pointer |
| new_msp | output | 32 | Resulting master stack pointer |

## Verification
The hardest state to reach from the ports is a return that walks through a format-1 frame and then continues on the other stack, because it needs two consistent frames on two stacks with matching status words. The bench gets there by first taking a hardware interrupt with the master bit set, which builds exactly that pair of frames in the bench memory, and then immediately issuing a return with the resulting SR and stack pointers, so the round trip must land back on the original SR, PC and both original stack pointers. The memory model stalls `mem_ready` on a repeating pattern so every access also sees wait cycles.

// File: rtl/exc_frame_pkg.sv
package exc_frame_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_VEC,
    ST_POP,
    ST_DONE
  } seq_st_t;

  localparam int SR_TRACE = 15;
  localparam int SR_SUPER = 13;
  localparam int SR_MSTR  = 12;
  localparam int SR_MASK0 = 8;

  localparam logic [2:0] LAST_PUSH_STEP = 3'd4;
  localparam logic [2:0] LAST_POP_STEP  = 3'd2;
endpackage

// File: rtl/exc_push_item.sv
module exc_push_item #(
  parameter int VEC_W = 8
) (
  input  logic [2:0]       step,
  input  logic [3:0]       fmt,
  input  logic [VEC_W-1:0] vec,
  input  logic [31:0]      pc,
  input  logic [31:0]      fault,
  input  logic [31:0]      ret,
  input  logic [15:0]      stk_sr,
  output logic             use_it,
  output logic             is_long,
  output logic [31:0]      data
);
  localparam int OFS_W = 12;
  logic [OFS_W-1:0] ofs;

  always_comb begin
    ofs     = OFS_W'({vec, 2'b00});
    use_it  = 1'b1;
    is_long = 1'b1;
    data    = 32'h0;
    unique case (step)
      3'd0: begin
        use_it = (fmt == 4'd4);
        data   = pc;
      end
      3'd1: begin
        use_it = (fmt == 4'd2) || (fmt == 4'd3) || (fmt == 4'd4);
        data   = fault;
      end
      3'd2: begin
        is_long = 1'b0;
        data    = {16'h0, fmt, ofs};
      end
      3'd3: data = ret;
      default: begin
        is_long = 1'b0;
        data    = {16'h0, stk_sr};
      end
    endcase
  end
endmodule

// File: rtl/exc_ret_skip.sv
module exc_ret_skip (
  input  logic [3:0] fmt,
  output logic       ok,
  output logic       restart,
  output logic [5:0] skip
);
  always_comb begin
    ok      = 1'b1;
    restart = 1'b0;
    skip    = 6'd0;
    unique case (fmt)
      4'd0: skip = 6'd0;
      4'd1: restart = 1'b1;
      4'd2, 4'd3: skip = 6'd4;
      4'd4: skip = 6'd8;
      4'd7: skip = 6'd52;
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
  import exc_frame_pkg::*;
#(
  parameter int VEC_W        = 8,
  parameter int TRAP_LO      = 32,
  parameter int TRAP_HI      = 47,
  parameter int IRQ_LO       = 24,
  parameter int IRQ_HI       = 31,
  parameter bit UNALIGNED_OK = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_entry,
  input  logic             start_return,
  input  logic [VEC_W-1:0] vec_num,
  input  logic [3:0]       entry_fmt,
  input  logic             hw_irq,
  input  logic [2:0]       irq_level,
  input  logic [31:0]      fault_addr,
  input  logic [31:0]      cur_pc,
  input  logic [31:0]      vbr,
  input  logic [15:0]      cur_sr,
  input  logic [31:0]      cur_isp,
  input  logic [31:0]      cur_msp,
  output logic             mem_valid,
  output logic             mem_write,
  output logic             mem_long,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ready,
  input  logic [31:0]      mem_rdata,
  output logic             busy,
  output logic             done,
  output logic             fmt_err,
  output logic             irq_rejected,
  output logic [31:0]      new_pc,
  output logic [15:0]      new_sr,
  output logic [31:0]      new_isp,
  output logic [31:0]      new_msp
);
  seq_st_t          st_q, st_d;
  logic [2:0]       step_q, step_d;
  logic [3:0]       fmt_q, fmt_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             tw_q, tw_d, entry_q, entry_d, err_q, err_d, rej_q, rej_d;
  logic [31:0]      sp_q, sp_d, isp_q, isp_d, msp_q, msp_d, pc_q, pc_d;
  logic [31:0]      ret_q, ret_d, fa_q, fa_d, vbr_q, vbr_d, pop_pc_q, pop_pc_d;
  logic [31:0]      o_isp_q, o_isp_d, o_msp_q, o_msp_d, epc_q, epc_d;
  logic [15:0]      sr_q, sr_d, stk_q, stk_d, pop_sr_q, pop_sr_d, o_sr_q, o_sr_d;

  logic        it_use, it_long;
  logic [31:0] it_data;
  logic        rs_ok, rs_restart;
  logic [5:0]  rs_skip;

  exc_push_item #(.VEC_W(VEC_W)) u_item (
    .step(step_q), .fmt(fmt_q), .vec(vec_q), .pc(epc_q), .fault(fa_q),
    .ret(ret_q), .stk_sr(stk_q), .use_it(it_use), .is_long(it_long),
    .data(it_data)
  );

  exc_ret_skip u_skip (
    .fmt(mem_rdata[15:12]), .ok(rs_ok), .restart(rs_restart), .skip(rs_skip)
  );

  function automatic logic [31:0] align_sp(input logic [31:0] sp);
    return UNALIGNED_OK ? sp : {sp[31:1], 1'b0};
  endfunction

  logic [15:0] sr_entry;
  logic        accept, fmt_ok, is_trap, is_tw;
  logic [31:0] push_addr, pop_end, isp_n, msp_n;

  always_comb begin
    sr_entry = cur_sr;
    sr_entry[SR_SUPER] = 1'b1;
    sr_entry[SR_TRACE] = 1'b0;
    if (hw_irq) sr_entry[SR_MASK0+2:SR_MASK0] = irq_level;
    accept  = !hw_irq || (cur_sr[SR_MASK0+2:SR_MASK0] < irq_level);
    fmt_ok  = hw_irq || (entry_fmt == 4'd0) || (entry_fmt == 4'd2) ||
              (entry_fmt == 4'd3) || (entry_fmt == 4'd4);
    is_trap = !hw_irq && (int'(vec_num) >= TRAP_LO) && (int'(vec_num) <= TRAP_HI);
    is_tw   = hw_irq && cur_sr[SR_MSTR] &&
              (int'(vec_num) >= IRQ_LO) && (int'(vec_num) <= IRQ_HI);
    push_addr = sp_q - (it_long ? 32'd4 : 32'd2);
    pop_end   = sp_q + 32'd8 + 32'(rs_skip);
    isp_n     = sr_q[SR_MSTR] ? isp_q : pop_end;
    msp_n     = sr_q[SR_MSTR] ? pop_end : msp_q;
  end

  always_comb begin
    st_d = st_q; step_d = step_q; fmt_d = fmt_q; vec_d = vec_q;
    tw_d = tw_q; entry_d = entry_q; err_d = err_q; rej_d = rej_q;
    sp_d = sp_q; isp_d = isp_q; msp_d = msp_q; pc_d = pc_q;
    ret_d = ret_q; fa_d = fa_q; vbr_d = vbr_q; pop_pc_d = pop_pc_q;
    o_isp_d = o_isp_q; o_msp_d = o_msp_q; epc_d = epc_q;
    sr_d = sr_q; stk_d = stk_q; pop_sr_d = pop_sr_q; o_sr_d = o_sr_q;
    mem_valid = 1'b0; mem_write = 1'b0; mem_long = 1'b0;
    mem_addr = 32'h0; mem_wdata = 32'h0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_entry || start_return) begin
          err_d = 1'b0; rej_d = 1'b0; entry_d = start_entry;
          pc_d = cur_pc; sr_d = cur_sr; isp_d = cur_isp; msp_d = cur_msp;
          o_sr_d = cur_sr; o_isp_d = cur_isp; o_msp_d = cur_msp;
          step_d = 3'd0;
        end
        if (start_entry) begin
          if (!accept) begin
            rej_d = 1'b1; st_d = ST_DONE;
          end else if (!fmt_ok) begin
            err_d = 1'b1; st_d = ST_DONE;
          end else begin
            sr_d  = sr_entry;
            stk_d = cur_sr;
            fmt_d = hw_irq ? 4'd0 : entry_fmt;
            tw_d  = is_tw;
            vec_d = vec_num;
            epc_d = cur_pc;
            ret_d = cur_pc + (is_trap ? 32'd2 : 32'd0);
            fa_d  = fault_addr;
            vbr_d = vbr;
            sp_d  = align_sp(sr_entry[SR_MSTR] ? cur_msp : cur_isp);
            st_d  = ST_PUSH;
          end
        end else if (start_return) begin
          sp_d = cur_sr[SR_MSTR] ? cur_msp : cur_isp;
          st_d = ST_POP;
        end
      end
      ST_PUSH: begin
        if (!it_use) begin
          step_d = step_q + 3'd1;
        end else begin
          mem_valid = 1'b1; mem_write = 1'b1; mem_long = it_long;
          mem_addr = push_addr; mem_wdata = it_data;
          if (mem_ready) begin
            sp_d = push_addr;
            step_d = step_q + 3'd1;
            if (step_q == LAST_PUSH_STEP) begin
              if (tw_q) begin
                msp_d = push_addr;
                stk_d = sr_q;
                sr_d  = sr_q & ~(16'h1 << SR_MSTR);
                sp_d  = align_sp(isp_q);
                fmt_d = 4'd1;
                tw_d  = 1'b0;
                step_d = 3'd0;
              end else begin
                if (sr_q[SR_MSTR]) msp_d = push_addr;
                else               isp_d = push_addr;
                st_d = ST_VEC;
              end
            end
          end
        end
      end
      ST_VEC: begin
        mem_valid = 1'b1; mem_long = 1'b1;
        mem_addr = vbr_q + 32'({vec_q, 2'b00});
        if (mem_ready) begin
          pc_d = mem_rdata;
          st_d = ST_DONE;
        end
      end
      ST_POP: begin
        mem_valid = 1'b1;
        mem_long  = (step_q == 3'd1);
        mem_addr  = sp_q + ((step_q == 3'd0) ? 32'd0 :
                            (step_q == 3'd1) ? 32'd2 : 32'd6);
        if (mem_ready) begin
          step_d = step_q + 3'd1;
          if (step_q == 3'd0) pop_sr_d = mem_rdata[15:0];
          if (step_q == 3'd1) pop_pc_d = mem_rdata;
          if (step_q == LAST_POP_STEP) begin
            if (!rs_ok) begin
              err_d = 1'b1;
              sr_d = o_sr_q; isp_d = o_isp_q; msp_d = o_msp_q;
              st_d = ST_DONE;
            end else begin
              isp_d = isp_n; msp_d = msp_n; sr_d = pop_sr_q;
              if (rs_restart) begin
                sp_d = pop_sr_q[SR_MSTR] ? msp_n : isp_n;
                step_d = 3'd0;
              end else begin
                pc_d = pop_pc_q;
                st_d = ST_DONE;
              end
            end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; step_q <= 3'd0; fmt_q <= 4'd0; vec_q <= '0;
      tw_q <= 1'b0; entry_q <= 1'b0; err_q <= 1'b0; rej_q <= 1'b0;
      sp_q <= 32'h0; isp_q <= 32'h0; msp_q <= 32'h0; pc_q <= 32'h0;
      ret_q <= 32'h0; fa_q <= 32'h0; vbr_q <= 32'h0; pop_pc_q <= 32'h0;
      o_isp_q <= 32'h0; o_msp_q <= 32'h0; epc_q <= 32'h0;
      sr_q <= 16'h0; stk_q <= 16'h0; pop_sr_q <= 16'h0; o_sr_q <= 16'h0;
    end else begin
      st_q <= st_d; step_q <= step_d; fmt_q <= fmt_d; vec_q <= vec_d;
      tw_q <= tw_d; entry_q <= entry_d; err_q <= err_d; rej_q <= rej_d;
      sp_q <= sp_d; isp_q <= isp_d; msp_q <= msp_d; pc_q <= pc_d;
      ret_q <= ret_d; fa_q <= fa_d; vbr_q <= vbr_d; pop_pc_q <= pop_pc_d;
      o_isp_q <= o_isp_d; o_msp_q <= o_msp_d; epc_q <= epc_d;
      sr_q <= sr_d; stk_q <= stk_d; pop_sr_q <= pop_sr_d; o_sr_q <= o_sr_d;
    end
  end

  assign busy         = (st_q == ST_PUSH) || (st_q == ST_VEC) || (st_q == ST_POP);
  assign done         = (st_q == ST_DONE);
  assign fmt_err      = done && err_q;
  assign irq_rejected = done && rej_q;
  assign new_pc       = pc_q;
  assign new_sr       = sr_q;
  assign new_isp      = isp_q;
  assign new_msp      = msp_q;

  // R12: request held stable until accepted
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
    $stable(mem_wdata) && $stable(mem_write) && $stable(mem_long));

  // R12: bus activity only while busy, busy low on completion
  p_bus_in_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy);
  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_valid);

  // R8: pushes land on even addresses when alignment is enforced
  p_push_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!UNALIGNED_OK && mem_valid && mem_write) |-> !mem_addr[0]);

  // R1: a masked interrupt finishes on the next cycle without bus traffic
  p_masked_irq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) && start_entry && hw_irq &&
    !(cur_sr[SR_MASK0+2:SR_MASK0] < irq_level) |=> irq_rejected && !mem_valid);

  // R2: completed entries leave supervisor set and trace clear
  p_entry_sr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done && entry_q && !err_q && !rej_q |-> new_sr[SR_SUPER] && !new_sr[SR_TRACE]);
endmodule

// File: tb/tb_exc_frame_seq.sv
module tb_exc_frame_seq;
  logic clk, rst_n;
  logic start_entry, start_return, hw_irq;
  logic [7:0]  vec_num;
  logic [3:0]  entry_fmt;
  logic [2:0]  irq_level;
  logic [31:0] fault_addr, cur_pc, vbr, cur_isp, cur_msp;
  logic [15:0] cur_sr;
  logic mem_valid, mem_write, mem_long, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic busy, done, fmt_err, irq_rejected;
  logic [31:0] new_pc, new_isp, new_msp;
  logic [15:0] new_sr;

  int checks = 0, failures = 0, accesses = 0, cycles = 0;
  logic [7:0] bmem [0:1023];
  logic [1:0] rdy_cnt;

  exc_frame_seq dut (
    .clk(clk), .rst_n(rst_n), .start_entry(start_entry), .start_return(start_return),
    .vec_num(vec_num), .entry_fmt(entry_fmt), .hw_irq(hw_irq), .irq_level(irq_level),
    .fault_addr(fault_addr), .cur_pc(cur_pc), .vbr(vbr), .cur_sr(cur_sr),
    .cur_isp(cur_isp), .cur_msp(cur_msp), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_long(mem_long), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .fmt_err(fmt_err), .irq_rejected(irq_rejected), .new_pc(new_pc),
    .new_sr(new_sr), .new_isp(new_isp), .new_msp(new_msp)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    rdy_cnt   <= (rst_n) ? rdy_cnt + 2'd1 : 2'd0;
    mem_ready <= rst_n && (rdy_cnt != 2'd2);
  end

  always_comb begin
    mem_rdata = 32'h0;
    if (mem_long)
      mem_rdata = {bmem[mem_addr[9:0]], bmem[mem_addr[9:0]+10'd1],
                   bmem[mem_addr[9:0]+10'd2], bmem[mem_addr[9:0]+10'd3]};
    else
      mem_rdata = {16'h0, bmem[mem_addr[9:0]], bmem[mem_addr[9:0]+10'd1]};
  end

  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      accesses <= accesses + 1;
      if (mem_write) begin
        if (mem_long) begin
          bmem[mem_addr[9:0]]       <= mem_wdata[31:24];
          bmem[mem_addr[9:0]+10'd1] <= mem_wdata[23:16];
          bmem[mem_addr[9:0]+10'd2] <= mem_wdata[15:8];
          bmem[mem_addr[9:0]+10'd3] <= mem_wdata[7:0];
        end else begin
          bmem[mem_addr[9:0]]       <= mem_wdata[15:8];
          bmem[mem_addr[9:0]+10'd1] <= mem_wdata[7:0];
        end
      end
    end
  end

  function automatic logic [31:0] rd32(input int a);
    return {bmem[a], bmem[a+1], bmem[a+2], bmem[a+3]};
  endfunction
  function automatic logic [31:0] rd16(input int a);
    return {16'h0, bmem[a], bmem[a+1]};
  endfunction
  task automatic wr16(input int a, input logic [15:0] v);
    bmem[a] = v[15:8]; bmem[a+1] = v[7:0];
  endtask
  task automatic wr32(input int a, input logic [31:0] v);
    wr16(a, v[31:16]); wr16(a+2, v[15:0]);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 100000);
        finish_run();
      end
    end
  end

  task automatic setup(input logic [15:0] sr, input logic [31:0] pc,
                       input logic [31:0] isp, input logic [31:0] msp);
    cur_sr = sr; cur_pc = pc; cur_isp = isp; cur_msp = msp;
  endtask

  task automatic run(input bit is_entry);
    int n = 0;
    @(negedge clk);
    accesses = 0;
    start_entry = is_entry; start_return = !is_entry;
    @(negedge clk);
    start_entry = 1'b0; start_return = 1'b0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      failures++;
      $display("FAIL R12 done never seen: actual=0 expected=1");
    end
  endtask

  task automatic sw_entry(input logic [7:0] v, input logic [3:0] f);
    vec_num = v; entry_fmt = f; hw_irq = 1'b0; run(1'b1);
  endtask
  task automatic hw_entry(input logic [7:0] v, input logic [2:0] lvl);
    vec_num = v; entry_fmt = 4'd0; hw_irq = 1'b1; irq_level = lvl; run(1'b1);
  endtask

  task automatic t_reset();
    chk("R12", "busy after reset", 32'(busy), 0);
    chk("R12", "done after reset", 32'(done), 0);
    chk("R12", "mem_valid after reset", 32'(mem_valid), 0);
  endtask

  task automatic t_fmt0();
    setup(16'h8015, 32'h1000, 32'h380, 32'h3C0);
    sw_entry(8'd5, 4'd0);
    chk("R2", "new_sr", 32'(new_sr), 32'h2015);
    chk("R3", "format word", rd16(32'h37E), 32'h0014);
    chk("R3", "return addr", rd32(32'h37A), 32'h1000);
    chk("R2", "stacked old sr", rd16(32'h378), 32'h8015);
    chk("R3", "new_isp", new_isp, 32'h378);
    chk("R3", "new_msp untouched", new_msp, 32'h3C0);
    chk("R7", "handler pc", new_pc, 32'hC0DE0005);
    chk("R7", "access count", 32'(accesses), 4);
  endtask

  task automatic t_trap();
    setup(16'h2000, 32'h2000, 32'h380, 32'h3C0);
    sw_entry(8'd33, 4'd0);
    chk("R5", "trap return addr", rd32(32'h37A), 32'h2002);
    chk("R3", "trap format word", rd16(32'h37E), 32'h0084);
    chk("R7", "trap handler", new_pc, 32'hC0DE0021);
  endtask

  task automatic t_fmt2();
    setup(16'h2000, 32'h1100, 32'h380, 32'h3C0);
    fault_addr = 32'hDEAD0001;
    sw_entry(8'd3, 4'd2);
    chk("R4", "fmt2 fault addr", rd32(32'h37C), 32'hDEAD0001);
    chk("R4", "fmt2 format word", rd16(32'h37A), 32'h200C);
    chk("R4", "fmt2 ret", rd32(32'h376), 32'h1100);
    chk("R4", "fmt2 sp", new_isp, 32'h374);
    chk("R4", "fmt2 accesses", 32'(accesses), 5);
  endtask

  task automatic t_fmt4();
    setup(16'h2000, 32'h3000, 32'h380, 32'h3C0);
    fault_addr = 32'h00BEEF00;
    sw_entry(8'd4, 4'd4);
    chk("R4", "fmt4 pc word", rd32(32'h37C), 32'h3000);
    chk("R4", "fmt4 addr word", rd32(32'h378), 32'h00BEEF00);
    chk("R4", "fmt4 format word", rd16(32'h376), 32'h4010);
    chk("R4", "fmt4 sp", new_isp, 32'h370);
  endtask

  task automatic t_hw_accept();
    setup(16'h2204, 32'h5000, 32'h380, 32'h3C0);
    hw_entry(8'd29, 3'd5);
    chk("R2", "irq new_sr mask", 32'(new_sr), 32'h2504);
    chk("R2", "irq stacked sr", rd16(32'h378), 32'h2204);
    chk("R4", "irq format word", rd16(32'h37E), 32'h0074);
    chk("R1", "irq accepted", 32'(irq_rejected), 0);
  endtask

  task automatic t_master_sw();
    setup(16'h3000, 32'h5000, 32'h380, 32'h3C0);
    sw_entry(8'd5, 4'd0);
    chk("R3", "master stack sp", new_msp, 32'h3B8);
    chk("R3", "isp untouched", new_isp, 32'h380);
  endtask

  task automatic t_hw_reject();
    setup(16'h2500, 32'h5000, 32'h380, 32'h3C0);
    hw_entry(8'd29, 3'd5);
    chk("R1", "rejected flag", 32'(irq_rejected), 1);
    chk("R1", "no accesses", 32'(accesses), 0);
    chk("R1", "sr unchanged", 32'(new_sr), 32'h2500);
    chk("R1", "isp unchanged", new_isp, 32'h380);
  endtask

  task automatic t_throwaway_roundtrip();
    setup(16'h3100, 32'h4000, 32'h380, 32'h3C0);
    hw_entry(8'd27, 3'd3);
    chk("R6", "msp after", new_msp, 32'h3B8);
    chk("R6", "isp after", new_isp, 32'h378);
    chk("R6", "final sr", 32'(new_sr), 32'h2300);
    chk("R6", "msp fmt0 word", rd16(32'h3BE), 32'h006C);
    chk("R6", "msp stacked sr", rd16(32'h3B8), 32'h3100);
    chk("R6", "isp fmt1 word", rd16(32'h37E), 32'h106C);
    chk("R6", "isp ret", rd32(32'h37A), 32'h4000);
    chk("R6", "isp stacked sr", rd16(32'h378), 32'h3300);
    chk("R6", "accesses", 32'(accesses), 7);
    setup(new_sr, 32'h9999, new_isp, new_msp);
    run(1'b0);
    chk("R10", "rt sr", 32'(new_sr), 32'h3100);
    chk("R10", "rt pc", new_pc, 32'h4000);
    chk("R10", "rt isp", new_isp, 32'h380);
    chk("R10", "rt msp", new_msp, 32'h3C0);
    chk("R10", "rt accesses", 32'(accesses), 6);
  endtask

  task automatic t_align();
    setup(16'h2000, 32'h1000, 32'h381, 32'h3C0);
    sw_entry(8'd5, 4'd0);
    chk("R8", "aligned sp", new_isp, 32'h378);
    chk("R8", "aligned fw", rd16(32'h37E), 32'h0014);
  endtask

  task automatic t_return(input logic [3:0] f, input int skip);
    wr16(32'h340, 16'h0004);
    wr32(32'h342, 32'h12345678);
    wr16(32'h346, {f, 12'h018});
    setup(16'h2000, 32'h7777, 32'h340, 32'h3C0);
    run(1'b0);
    chk("R9", "ret sp", new_isp, 32'h348 + 32'(skip));
    chk("R9", "ret sr", 32'(new_sr), 32'h0004);
    chk("R9", "ret pc", new_pc, 32'h12345678);
    chk("R9", "ret err", 32'(fmt_err), 0);
  endtask

  task automatic t_bad_return();
    wr16(32'h346, 16'h5018);
    setup(16'h2000, 32'h7777, 32'h340, 32'h3C0);
    run(1'b0);
    chk("R11", "bad fmt flag", 32'(fmt_err), 1);
    chk("R11", "bad fmt sp", new_isp, 32'h340);
    chk("R11", "bad fmt sr", 32'(new_sr), 32'h2000);
    chk("R11", "bad fmt pc", new_pc, 32'h7777);
  endtask

  task automatic t_bad_entry();
    setup(16'h2000, 32'h1000, 32'h380, 32'h3C0);
    sw_entry(8'd5, 4'd6);
    chk("R11", "entry fmt flag", 32'(fmt_err), 1);
    chk("R11", "entry no access", 32'(accesses), 0);
    chk("R11", "entry sp", new_isp, 32'h380);
  endtask

  initial begin
    rst_n = 1'b0; rdy_cnt = 2'd0; mem_ready = 1'b0;
    start_entry = 1'b0; start_return = 1'b0; hw_irq = 1'b0;
    vec_num = 8'd0; entry_fmt = 4'd0; irq_level = 3'd0;
    fault_addr = 32'h0; cur_pc = 32'h0; vbr = 32'h100;
    cur_sr = 16'h0; cur_isp = 32'h0; cur_msp = 32'h0;
    for (int i = 0; i < 1024; i++) bmem[i] = 8'h00;
    for (int v = 0; v < 48; v++) wr32(32'h100 + 4*v, 32'hC0DE0000 + 32'(v));
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_fmt0();
    t_trap();
    t_fmt2();
    t_fmt4();
    t_hw_accept();
    t_master_sw();
    t_hw_reject();
    t_throwaway_roundtrip();
    t_align();
    t_return(4'd0, 0);
    t_return(4'd2, 4);
    t_return(4'd3, 4);
    t_return(4'd4, 8);
    t_return(4'd7, 52);
    t_bad_return();
    t_bad_entry();
    finish_run();
  end
endmodule